// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescaler

This block supervises a small 8-bit controller. A free-running timebase divides the system clock by twelve and then by a power of two picked by a 4-bit mode input. Each output of that chain is one watchdog tick. An 8-bit counter totals the ticks. If software fails to refresh it for 256 ticks, the block raises a reset request for the rest of the chip.

Software refreshes the count through a plain register write port with an address, a data byte and a write strobe. Writing the key byte 0x55 to the refresh register restarts the whole timeout. The same write also clears a sticky "watchdog fired" flag. That flag sits in bit 7 of the status register and stays set across the reset that the watchdog itself asks for.

The enable and the mode come from static option inputs and are meant to change only while the external reset is held. All interfaces are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `kwdt_top`

## Requirements
- R1: When `cfg_en` is 0, the tick counter does not advance and `wd_rst_o` never goes high.
- R2: The watchdog tick period is 12 × 2^M system clocks, where M is `cfg_mode` (0 to 15).
- R3: Without a refresh, `wd_rst_o` rises exactly 12 × 2^M × 256 clock edges after the edge that captured the last refresh.
- R4: A write of 0x55 to address 0xB7 clears the tick counter and both prescaler stages, so repeated refreshes inside the window keep `wd_rst_o` low.
- R5: On overflow, bit 7 of the register at address 0xB6 becomes 1 and reads back 0x80.
- R6: `wd_rst_o` is high for exactly 4 clocks. The timebase and counter are held cleared meanwhile, so the next timeout runs a full window from the edge where `wd_rst_o` falls. The flag stays 1 through the pulse.
- R7: A write of 0x55 to address 0xB7 clears the flag at address 0xB6.
- R8: A write of any other value to address 0xB7 leaves the counter, the prescaler and the flag unchanged.
- R9: Bits 6..0 of address 0xB6 read 0, and writes to 0xB6 have no effect. Address 0xB7 always reads 0x00.
- R10: While `rst_n` is low, the counter, prescaler, flag and pulse are cleared. Afterwards both registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External asynchronous reset, active low |
| cfg_en | input | 1 | Static option: watchdog enable |
| cfg_mode | input | 4 | Static option: prescaler exponent M |
| sfr_addr | input | 8 | Register address for both write and read |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe, one clock per write |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| wd_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The embedded properties check the following on every clock:
- the counter wraps to zero on overflow;
- a valid key leaves the count and flag cleared;
- an overflow raises both the flag and a pulse loaded with its full length;
- the count stays frozen while the block is disabled;
- unused status bits and the key address read zero.

Some behaviour can only be shown by the bench scenarios. These are the exact timeout length for several mode values, the four-clock pulse width, and the full window that follows a pulse. The bench also shows that stray key values and status writes are ignored, and that an external reset clears a flag left by an earlier timeout.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0] KW_ADDR_STAT = 8'hB6;
  localparam logic [7:0] KW_ADDR_KEY  = 8'hB7;
  localparam logic [7:0] KW_KEY_VAL   = 8'h55;
  localparam int         KW_FLAG_BIT  = 7;

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [7:0] data;
  } kw_wr_t;
endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int PRE_DIV = 12,
  parameter int MODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [MODE_W-1:0] mode,
  output logic              tick
);
  localparam int DIV_W   = $clog2(PRE_DIV);
  localparam int SCALE_W = (1 << MODE_W) - 1;

  logic [DIV_W-1:0]   div_q;
  logic [SCALE_W-1:0] scale_q;
  logic [SCALE_W:0]   span;
  logic [SCALE_W-1:0] mask;
  logic               pre;

  always_comb begin
    span = '0;
    span[mode] = 1'b1;
    mask = SCALE_W'(span - 1'b1);
  end

  assign pre  = run && (div_q == DIV_W'(PRE_DIV - 1));
  assign tick = pre && (scale_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      scale_q <= '0;
    end else if (clr) begin
      div_q   <= '0;
      scale_q <= '0;
    end else if (run) begin
      div_q <= pre ? '0 : div_q + 1'b1;
      if (pre) scale_q <= (scale_q == mask) ? '0 : scale_q + 1'b1;
    end
  end

  // R2: the power-of-two stage only moves on a predivider wrap
  p_scale_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pre) |=> $stable(scale_q));
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign ovf = tick && !clr && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  kw_wr_t     wr,
  input  logic [7:0] rd_addr,
  input  logic       ovf,
  output logic       kick,
  output logic       hold,
  output logic       flag,
  output logic       wd_rst,
  output logic [7:0] rdata
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pulse_q;

  assign kick   = wr.we && (wr.addr == KW_ADDR_KEY) && (wr.data == KW_KEY_VAL);
  assign wd_rst = (pulse_q != '0);
  assign hold   = wd_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pulse_q <= '0;
    else if (ovf)     pulse_q <= PW'(PULSE_LEN);
    else if (wd_rst)  pulse_q <= pulse_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (ovf)     flag <= 1'b1;
    else if (kick)    flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd_addr == KW_ADDR_STAT) rdata[KW_FLAG_BIT] = flag;
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);
  p_pulse_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (wd_rst && pulse_q == PW'(PULSE_LEN)));
  p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst && flag) |=> flag);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !ovf) |=> !flag);
  p_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6:0] == 7'd0);
  p_key_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == KW_ADDR_KEY) |-> (rdata == 8'h00));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int PRE_DIV   = 12,
  parameter int MODE_W    = 4,
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [7:0]        sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              sfr_we,
  output logic [7:0]        sfr_rdata,
  output logic              wd_rst_o
);
  kw_wr_t           wr;
  logic             kick, hold, flag, tick, ovf, clr;
  logic [CNT_W-1:0] cnt;

  assign wr.we   = sfr_we;
  assign wr.addr = sfr_addr;
  assign wr.data = sfr_wdata;
  assign clr     = kick || hold;

  kwdt_prescale #(.PRE_DIV(PRE_DIV), .MODE_W(MODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cfg_en), .clr(clr),
    .mode(cfg_mode), .tick(tick)
  );

  kwdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr),
    .cnt(cnt), .ovf(ovf)
  );

  kwdt_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(wr), .rd_addr(sfr_addr), .ovf(ovf),
    .kick(kick), .hold(hold), .flag(flag), .wd_rst(wd_rst_o),
    .rdata(sfr_rdata)
  );

  p_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !clr) |=> $stable(cnt));
  p_no_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !ovf);
  p_quiet_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |-> !ovf);
endmodule

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b1;
  logic [3:0] cfg_mode = 4'd0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       wd_rst_o;

  int nchk = 0;
  int nerr = 0;
  longint cyc = 0;
  longint ref_cyc = 0;
  int rises = 0;
  int falls = 0;
  longint exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kwdt_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
    .sfr_rdata(sfr_rdata), .wd_rst_o(wd_rst_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic longint window(input int m);
    return longint'(12) * (longint'(1) << m) * 256;
  endfunction

  // monitor: pops expected timeout lengths, checks pulse width
  logic   prev_rst = 1'b0;
  int     width = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wd_rst_o && !prev_rst) begin
        longint e;
        rises++;
        if (exp_q.size() == 0) check(1'b0, "R1/R4 unexpected reset", cyc - ref_cyc, -1);
        else begin
          e = exp_q.pop_front();
          check(cyc - ref_cyc == e, "R3 timeout", cyc - ref_cyc, e);
        end
        width = 1;
      end else if (wd_rst_o) width++;
      if (!wd_rst_o && prev_rst) begin
        falls++;
        check(width == 4, "R6 pulse width", width, 4);
        ref_cyc = cyc;
      end
    end
    prev_rst = wd_rst_o;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(posedge clk);
    #1;
    if (a == 8'hB7 && d == 8'h55) ref_cyc = cyc;
    @(negedge clk);
    sfr_we = 1'b0; sfr_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    sfr_addr = a;
    #1;
    check(sfr_rdata == e, req, sfr_rdata, e);
    sfr_addr = 8'h00;
  endtask

  task automatic do_reset(input bit en, input logic [3:0] m);
    @(negedge clk);
    rst_n = 1'b0; cfg_en = en; cfg_mode = m;
    repeat (3) @(negedge clk);
    check(wd_rst_o == 1'b0, "R10 output low in reset", wd_rst_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic arm(input int m, input int n);
    wr(8'hB7, 8'h55);
    for (int i = 0; i < n; i++) exp_q.push_back(window(m));
  endtask

  task automatic wait_rises(input int k);
    wait (rises >= k);
    wait (falls >= k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    do_reset(1'b1, 4'd0);
    rd(8'hB6, 8'h00, "R10 status after reset");
    rd(8'hB7, 8'h00, "R10 key reg after reset");
    // R3 R6: two back-to-back windows at M=0, second measured from the fall
    arm(0, 2);
    wait (rises >= 1);
    rd(8'hB6, 8'h80, "R5 flag set during pulse");
    wait_rises(2);
    rd(8'hB6, 8'h80, "R6 flag kept after pulse");
    rd(8'hB7, 8'h00, "R9 key reads zero");
    // R9: write to status ignored
    wr(8'hB6, 8'h00);
    rd(8'hB6, 8'h80, "R9 status write ignored");
    // R7: key clears flag
    arm(0, 1);
    rd(8'hB6, 8'h00, "R7 key clears flag");
    wait_rises(3);
    // R8: stray values do not refresh; R2 with M=1
    do_reset(1'b1, 4'd1);
    arm(1, 1);
    repeat (3000) @(posedge clk);
    wr(8'hB7, 8'hAA);
    wr(8'hB7, 8'h54);
    wr(8'hB6, 8'h55);
    rd(8'hB6, 8'h00, "R8 status untouched");
    wait_rises(4);
    rd(8'hB6, 8'h80, "R8 flag set after timeout");
    // R4: periodic refresh keeps output low
    arm(1, 1);
    for (int i = 0; i < 3; i++) begin
      repeat (5000) @(posedge clk);
      wr(8'hB7, 8'h55);
    end
    check(rises == 4, "R4 no reset while refreshed", rises, 4);
    wait_rises(5);
    // R2 R3: larger mode values
    do_reset(1'b1, 4'd2);
    arm(2, 1);
    wait_rises(6);
    do_reset(1'b1, 4'd3);
    arm(3, 1);
    wait_rises(7);
    // R10: external reset clears a set flag
    rd(8'hB6, 8'h80, "R5 flag before ext reset");
    do_reset(1'b1, 4'd0);
    rd(8'hB6, 8'h00, "R10 flag cleared by reset");
    // R1: disabled watchdog never fires
    do_reset(1'b0, 4'd0);
    repeat (10000) @(posedge clk);
    check(rises == 7, "R1 disabled no reset", rises, 7);
    rd(8'hB6, 8'h00, "R1 flag stays clear");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule